// File: doc/BRIEF.md
# Multi-Mode ADC Channel Sequencer

This block chooses which analog multiplexer input a 16-channel serial ADC front end converts in each frame. A frame is the interval during which the active-low frame select is held low. Inside a frame the block counts falling edges of the serial clock. On the second falling edge it loads the next channel into the mux select register and pulses a one-cycle change strobe. Both the serial clock and the frame select are sampled by the system clock, so each serial clock phase must last at least one system clock period.

The next channel depends on the active mode. In manual mode it is a channel number that software wrote during the previous frame. In bitmap scan mode it is the next higher channel whose mask bit is set. In range scan mode it is the next channel from 0 up to a programmed last channel. The decoded register-write strobes and their values arrive from the command decoder. Both program registers keep their contents across mode changes and are restored to full-scan values only by reset or by a new write.

Top module: `adc_chan_sequencer`

## Requirements
- R1: After reset, `mux_sel` is 0, `ch_chg` is low and the mode is manual. A frame run with no manual write then selects channel 0.
- R2: `mux_sel` changes only on the system clock edge that samples the second falling `sclk` edge while `cs_n` is low. The first falling edge and the third or later falling edges in the same frame leave it unchanged.
- R3: In manual mode (mode code 2'b00), a channel written with `man_wr` during frame N does not affect frame N. It is selected at the switch point of frame N+1.
- R4: In bitmap scan mode (mode code 2'b01), bit i of the mask enables channel i. Each frame selects the lowest enabled channel above the current one. When no enabled channel is above the current one, it wraps to the lowest enabled channel.
- R5: In bitmap scan mode with an all-zero mask, each frame keeps the current channel.
- R6: In range scan mode (mode code 2'b10), each frame selects the current channel plus one. When the current channel is at or above the programmed last channel, it selects channel 0.
- R7: Reset sets the mask to 16'hFFFF and the last channel to 15, so either scan mode covers all 16 channels in ascending order.
- R8: Switching to manual mode and back does not alter the mask or the last-channel value.
- R9: The first frame after a write that selects a scan mode uses the lowest eligible channel: the lowest set mask bit, or channel 0 in range scan mode.
- R10: `ch_chg` is high for exactly one system clock cycle per switch point, in the same cycle that the new `mux_sel` value appears. It stays low at all other times.
- R11: A mode write with code 2'b11 is ignored. The current mode and scan position continue unchanged.
- R12: Raising `cs_n` clears the edge count. `sclk` edges while `cs_n` is high are ignored, and a frame that ends after one falling edge switches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, sampled on `clk` |
| cs_n | input | 1 | Active-low frame select, sampled on `clk` |
| mode_wr | input | 1 | Mode register write strobe |
| mode_val | input | 2 | Mode code: 00 manual, 01 bitmap scan, 10 range scan, 11 ignored |
| man_wr | input | 1 | Manual channel write strobe |
| man_val | input | 4 | Manual channel number |
| mask_wr | input | 1 | Scan mask write strobe |
| mask_val | input | 16 | Scan mask, bit i enables channel i |
| last_wr | input | 1 | Last-channel write strobe |
| last_val | input | 4 | Last channel of the range scan |
| mux_sel | output | 4 | Selected multiplexer channel |
| ch_chg | output | 1 | One-cycle strobe at each mux update |

## Verification
Manual mode is tested by sweeping all 16 channel numbers with writes placed in the middle of a frame. This separates selection in the next frame from selection in the same frame. Bitmap scan mode is tested with the reset mask, sparse masks, a single low bit, a single high bit and alternating masks. These patterns separate correct wrap-around from a simple increment, and an all-zero mask checks the hold behaviour. Range scan mode is tested with every last-channel value from 0 to 15, which covers the degenerate single-channel loop and the full 16-channel loop. Further tests cover mode re-entry, the ignored mode code, and aborted or idle frames, which check register retention, the restart point and the edge-count clearing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_MANUAL = 2'b00,
        SEQ_BITMAP = 2'b01,
        SEQ_RANGE  = 2'b10
    } seq_mode_e;

    localparam logic [1:0] SEQ_CODE_BAD = 2'b11;
endpackage

// File: rtl/adc_seq_frame_timer.sv
module adc_seq_frame_timer #(
    parameter int SWITCH_EDGE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic switch_o,
    output logic frame_start_o
);
    localparam int CNT_W = $clog2(SWITCH_EDGE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SWITCH_EDGE);
    localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(SWITCH_EDGE - 1);

    typedef struct packed {
        logic             sclk_prev;
        logic             cs_prev;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic fall;

    always_comb begin
        st_d          = st_q;
        fall          = st_q.sclk_prev & ~sclk;
        st_d.sclk_prev = sclk;
        st_d.cs_prev   = cs_n;
        // R12: the count is cleared whenever the frame select is high
        if (cs_n) begin
            st_d.cnt = '0;
        end else if (fall && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // R2: the switch fires on the falling edge that completes the count
        switch_o      = fall & ~cs_n & (st_q.cnt == CNT_HIT);
        frame_start_o = st_q.cs_prev & ~cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.cs_prev   <= 1'b1;
            st_q.cnt       <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/adc_seq_prog_regs.sv
module adc_seq_prog_regs
    import adc_seq_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_wr,
    input  logic [1:0]     mode_val,
    input  logic           man_wr,
    input  logic [CHW-1:0] man_val,
    input  logic           mask_wr,
    input  logic [NCH-1:0] mask_val,
    input  logic           last_wr,
    input  logic [CHW-1:0] last_val,
    input  logic           frame_start,
    input  logic           switch_ev,
    output seq_mode_e      mode_o,
    output logic [NCH-1:0] mask_o,
    output logic [CHW-1:0] last_o,
    output logic [CHW-1:0] man_arm_o,
    output logic           fresh_o
);
    typedef struct packed {
        seq_mode_e      mode;
        logic [NCH-1:0] mask;
        logic [CHW-1:0] last;
        logic [CHW-1:0] man_pend;
        logic [CHW-1:0] man_arm;
        logic           fresh;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // R3: the pending number is armed when a new frame begins
        if (frame_start) st_d.man_arm = st_q.man_pend;
        if (man_wr)      st_d.man_pend = man_val;
        // R8: program registers change only on their own writes
        if (mask_wr)     st_d.mask = mask_val;
        if (last_wr)     st_d.last = last_val;
        if (switch_ev)   st_d.fresh = 1'b0;
        // R11: the unused code leaves the mode untouched
        if (mode_wr && mode_val != SEQ_CODE_BAD) begin
            st_d.mode = seq_mode_e'(mode_val);
            // R9: entering a scan mode restarts at the lowest eligible channel
            if (mode_val != SEQ_MANUAL) st_d.fresh = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= SEQ_MANUAL;
            st_q.mask     <= '1;                 // R7
            st_q.last     <= CHW'(NCH - 1);      // R7
            st_q.man_pend <= '0;
            st_q.man_arm  <= '0;
            st_q.fresh    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign mask_o    = st_q.mask;
    assign last_o    = st_q.last;
    assign man_arm_o = st_q.man_arm;
    assign fresh_o   = st_q.fresh;
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick
    import adc_seq_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CHW = $clog2(NCH)
) (
    input  seq_mode_e      mode,
    input  logic [NCH-1:0] mask,
    input  logic [CHW-1:0] last,
    input  logic [CHW-1:0] cur,
    input  logic [CHW-1:0] man_arm,
    input  logic           fresh,
    output logic [CHW-1:0] next_o
);
    logic [CHW-1:0] low_ch;
    logic [CHW-1:0] above_ch;
    logic           above_hit;
    logic [CHW-1:0] range_nx;

    // lowest set bit, and lowest set bit strictly above the current channel
    always_comb begin
        low_ch    = '0;
        above_ch  = '0;
        above_hit = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) low_ch = CHW'(i);
            if (mask[i] && i > int'(cur)) begin
                above_ch  = CHW'(i);
                above_hit = 1'b1;
            end
        end
    end

    always_comb begin
        // R6: ascending range with wrap to 0 at or beyond the last channel
        range_nx = (cur >= last) ? '0 : cur + 1'b1;
        unique case (mode)
            SEQ_BITMAP: begin
                if (mask == '0)     next_o = cur;        // R5
                else if (fresh)     next_o = low_ch;     // R9
                else if (above_hit) next_o = above_ch;   // R4
                else                next_o = low_ch;     // R4 wrap
            end
            SEQ_RANGE:  next_o = fresh ? '0 : range_nx;
            default:    next_o = man_arm;                // R3
        endcase
    end
endmodule

// File: rtl/adc_chan_sequencer.sv
module adc_chan_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NCH         = 16,
    parameter int SWITCH_EDGE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     cs_n,
    input  logic                     mode_wr,
    input  logic [1:0]               mode_val,
    input  logic                     man_wr,
    input  logic [$clog2(NCH)-1:0]   man_val,
    input  logic                     mask_wr,
    input  logic [NCH-1:0]           mask_val,
    input  logic                     last_wr,
    input  logic [$clog2(NCH)-1:0]   last_val,
    output logic [$clog2(NCH)-1:0]   mux_sel,
    output logic                     ch_chg
);
    localparam int CHW = $clog2(NCH);

    typedef struct packed {
        logic [CHW-1:0] sel;
        logic           chg;
    } out_t;

    out_t           st_d, st_q;
    logic           switch_ev;
    logic           frame_start;
    seq_mode_e      cur_mode;
    logic [NCH-1:0] scan_mask;
    logic [CHW-1:0] last_ch;
    logic [CHW-1:0] man_arm;
    logic           fresh;
    logic [CHW-1:0] next_ch;

    adc_seq_frame_timer #(.SWITCH_EDGE(SWITCH_EDGE)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk          (sclk),
        .cs_n          (cs_n),
        .switch_o      (switch_ev),
        .frame_start_o (frame_start)
    );

    adc_seq_prog_regs #(.NCH(NCH), .CHW(CHW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_val    (mode_val),
        .man_wr      (man_wr),
        .man_val     (man_val),
        .mask_wr     (mask_wr),
        .mask_val    (mask_val),
        .last_wr     (last_wr),
        .last_val    (last_val),
        .frame_start (frame_start),
        .switch_ev   (switch_ev),
        .mode_o      (cur_mode),
        .mask_o      (scan_mask),
        .last_o      (last_ch),
        .man_arm_o   (man_arm),
        .fresh_o     (fresh)
    );

    adc_seq_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .mode    (cur_mode),
        .mask    (scan_mask),
        .last    (last_ch),
        .cur     (st_q.sel),
        .man_arm (man_arm),
        .fresh   (fresh),
        .next_o  (next_ch)
    );

    always_comb begin
        st_d     = st_q;
        // R2, R10: load and strobe together at the switch point only
        st_d.chg = switch_ev;
        if (switch_ev) st_d.sel = next_ch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= '0;   // R1
            st_q.chg <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mux_sel = st_q.sel;
    assign ch_chg  = st_q.chg;
endmodule

// File: rtl/adc_chan_sequencer_chk.sv
module adc_chan_sequencer_chk
    import adc_seq_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CHW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cs_n,
    input logic [CHW-1:0] mux_sel,
    input logic           ch_chg,
    input seq_mode_e      mode,
    input logic [NCH-1:0] mask,
    input logic [CHW-1:0] last
);
    a_r2_change_needs_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel != $past(mux_sel)) |-> ch_chg);

    a_r10_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ch_chg |=> !ch_chg);

    a_r12_strobe_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ch_chg |-> !$past(cs_n));

    a_r5_empty_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_chg && $past(mode) == SEQ_BITMAP && $past(mask) == '0)
        |-> mux_sel == $past(mux_sel));

    a_r4_bitmap_member: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_chg && $past(mode) == SEQ_BITMAP && $past(mask) != '0)
        |-> ((($past(mask) >> mux_sel) & NCH'(1)) != '0));

    a_r6_range_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_chg && $past(mode) == SEQ_RANGE) |-> mux_sel <= $past(last));
endmodule

bind adc_chan_sequencer adc_chan_sequencer_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .mux_sel (mux_sel),
    .ch_chg  (ch_chg),
    .mode    (cur_mode),
    .mask    (scan_mask),
    .last    (last_ch)
);

// File: tb/adc_chan_sequencer_bench.sv
module adc_chan_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_val = 2'b00;
    logic        man_wr = 1'b0;
    logic [3:0]  man_val = 4'd0;
    logic        mask_wr = 1'b0;
    logic [15:0] mask_val = 16'h0;
    logic        last_wr = 1'b0;
    logic [3:0]  last_val = 4'd0;
    logic [3:0]  mux_sel;
    logic        ch_chg;

    int tests = 0;
    int fails = 0;
    int chg_cnt = 0;
    bit done = 1'b0;

    // reference state derived from the requirements
    int          m_mode, m_cur, m_pend, m_arm, m_last;
    bit          m_fresh;
    logic [15:0] m_mask;

    adc_chan_sequencer u_adc_chan_sequencer (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .mode_wr(mode_wr), .mode_val(mode_val), .man_wr(man_wr), .man_val(man_val),
        .mask_wr(mask_wr), .mask_val(mask_val), .last_wr(last_wr), .last_val(last_val),
        .mux_sel(mux_sel), .ch_chg(ch_chg)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (rst_n && ch_chg) chg_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_cur = 0; m_pend = 0; m_arm = 0;
        m_last = 15; m_mask = 16'hFFFF; m_fresh = 1'b0;
    endtask

    function automatic int model_next();
        int lo, ab;
        lo = -1; ab = -1;
        for (int i = 15; i >= 0; i--) begin
            if (m_mask[i]) lo = i;
            if (m_mask[i] && i > m_cur) ab = i;
        end
        case (m_mode)
            1: begin
                if (m_mask == 16'h0) return m_cur;
                if (m_fresh) return lo;
                return (ab >= 0) ? ab : lo;
            end
            2: begin
                if (m_fresh) return 0;
                return (m_cur >= m_last) ? 0 : m_cur + 1;
            end
            default: return m_arm;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1;
        tick(3);
        rst_n = 1'b1;
        model_reset();
        tick(2);
    endtask

    task automatic wr_mode(input logic [1:0] m);
        mode_val = m; mode_wr = 1'b1; tick(1); mode_wr = 1'b0; tick(1);
        if (m != 2'b11) begin
            m_mode = int'(m);
            if (m != 2'b00) m_fresh = 1'b1;
        end
    endtask

    task automatic wr_man(input int ch);
        man_val = 4'(ch); man_wr = 1'b1; tick(1); man_wr = 1'b0; tick(1);
        m_pend = ch;
    endtask

    task automatic wr_mask(input logic [15:0] v);
        mask_val = v; mask_wr = 1'b1; tick(1); mask_wr = 1'b0; tick(1);
        m_mask = v;
    endtask

    task automatic wr_last(input int v);
        last_val = 4'(v); last_wr = 1'b1; tick(1); last_wr = 1'b0; tick(1);
        m_last = v;
    endtask

    task automatic pulse();
        sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    endtask

    // full frame with npulses falling edges; optional manual write inside it
    task automatic frame(input string tag, input int npulses, input bit mid_wr, input int mid_ch);
        int prev, exp, c0;
        cs_n = 1'b0; m_arm = m_pend; tick(2);
        prev = int'(mux_sel); c0 = chg_cnt;
        exp = model_next();
        pulse();
        chk("R2 first edge holds", int'(mux_sel), prev);
        pulse();
        chk(tag, int'(mux_sel), exp);
        m_cur = exp; m_fresh = 1'b0;
        for (int k = 2; k < npulses; k++) pulse();
        chk("R2 later edges hold", int'(mux_sel), exp);
        chk("R10 one strobe per frame", chg_cnt - c0, 1);
        if (mid_wr) wr_man(mid_ch);
        cs_n = 1'b1; tick(2);
    endtask

    initial begin
        do_reset();
        chk("R1 reset mux", int'(mux_sel), 0);
        chk("R1 reset strobe", int'(ch_chg), 0);
        frame("R1 manual default", 3, 1'b0, 0);

        // R3: manual sweep, each write lands one frame later
        for (int c = 0; c < 16; c++) frame("R3 manual next frame", 2, 1'b1, 15 - c);
        frame("R3 manual last write", 2, 1'b0, 0);

        // R7 and R9: reset mask scans everything from channel 0
        wr_mode(2'b01);
        for (int f = 0; f < 18; f++) frame("R7 full bitmap scan", 2, 1'b0, 0);

        // R4: assorted masks, continuing from the current channel
        begin
            logic [15:0] masks [5] = '{16'h8421, 16'hA5A5, 16'h0001, 16'h8000, 16'h7FFE};
            foreach (masks[j]) begin
                wr_mask(masks[j]);
                for (int f = 0; f < $countones(masks[j]) + 2; f++)
                    frame("R4 bitmap ascending wrap", 2, 1'b0, 0);
            end
        end

        // R7: full range scan with reset last channel
        do_reset();
        wr_mode(2'b10);
        for (int f = 0; f < 17; f++) frame("R7 full range scan", 2, 1'b0, 0);

        // R6: every last-channel value
        for (int l = 0; l < 16; l++) begin
            wr_last(l);
            wr_mode(2'b10);
            for (int f = 0; f < l + 3; f++) frame("R6 range scan", 2, 1'b0, 0);
        end

        // R9: entering bitmap mode from mid-range starts at the lowest set bit
        wr_last(9);
        wr_mask(16'h0F00);
        frame("R6 range step", 2, 1'b0, 0);
        frame("R6 range step", 2, 1'b0, 0);
        wr_mode(2'b01);
        frame("R9 bitmap entry lowest", 2, 1'b0, 0);
        chk("R9 bitmap entry is 8", int'(mux_sel), 8);
        frame("R4 bitmap step", 2, 1'b0, 0);
        wr_mode(2'b10);
        frame("R9 range entry zero", 2, 1'b0, 0);
        chk("R9 range entry is 0", int'(mux_sel), 0);

        // R8: detour through manual keeps both program registers
        wr_last(5);
        wr_man(13);
        wr_mode(2'b00);
        frame("R8 manual detour", 2, 1'b0, 0);
        frame("R8 manual detour", 2, 1'b0, 0);
        wr_mode(2'b01);
        for (int f = 0; f < 6; f++) frame("R8 bitmap retained", 2, 1'b0, 0);
        wr_mode(2'b10);
        for (int f = 0; f < 8; f++) frame("R8 range retained", 2, 1'b0, 0);

        // R11: code 3 leaves the range scan running
        wr_man(14);
        wr_mode(2'b11);
        for (int f = 0; f < 4; f++) frame("R11 bad code ignored", 2, 1'b0, 0);

        // R5: empty mask holds the channel
        wr_mode(2'b01);
        frame("R4 bitmap step", 2, 1'b0, 0);
        frame("R4 bitmap step", 2, 1'b0, 0);
        wr_mask(16'h0000);
        for (int f = 0; f < 3; f++) frame("R5 empty mask hold", 2, 1'b0, 0);
        wr_mask(16'h0003);
        frame("R4 after empty mask", 2, 1'b0, 0);

        // R12: edges with frame select high, and an aborted frame
        begin
            int prev, c0;
            prev = int'(mux_sel); c0 = chg_cnt;
            for (int k = 0; k < 3; k++) pulse();
            chk("R12 idle edges mux", int'(mux_sel), prev);
            chk("R12 idle edges strobe", chg_cnt - c0, 0);
            cs_n = 1'b0; m_arm = m_pend; tick(2);
            pulse();
            cs_n = 1'b1; tick(2);
            chk("R12 aborted frame mux", int'(mux_sel), prev);
            chk("R12 aborted frame strobe", chg_cnt - c0, 0);
            frame("R12 count restarts", 2, 1'b0, 0);
        end

        // R1, R7: second reset restores manual mode and full mask
        wr_mask(16'h0010);
        do_reset();
        chk("R1 reset again mux", int'(mux_sel), 0);
        frame("R1 manual after reset", 2, 1'b0, 0);
        wr_mode(2'b01);
        for (int f = 0; f < 3; f++) frame("R7 mask restored", 2, 1'b0, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule